// File: doc/BRIEF.md
# Return-Stack Next-Fetch Sequencer

This block generates the instruction-fetch address for a core whose only control transfer is an absolute jump taken from a hardware return stack. Each decoded instruction can push an immediate address, push an address read from a register, and carry a return flag. A return does not redirect fetch straight away. It loads a registered target, the next instruction executes as a delay slot, and the fetch after that uses the target. Because the target is always sitting in a register one cycle before it is needed, fetch from a slow memory never waits on branch resolution.

Jumps, calls and chains of either are built from pushes and returns. A push combined with a return sends its address straight to the target register. A push in a delay slot lands under the target that is already pending. Addresses pushed in reverse order are taken by successive returns. An optional co-return flag stores the address after the delay slot as a link, so a call needs no separate push of its return address.

`fetch_addr_o` is the address of the instruction whose decoded flags are on the inputs in the same cycle. While `stall_i` is high that instruction is not consumed and every input is ignored.

Top module: `rsq_fetch_seq`

## Requirements
- R1: After a synchronous reset `fetch_addr_o` equals `RESET_ADDR`. Depth is 0, `stack_empty_o` is 1, `stack_full_o` is 0, and `overflow_o`, `underflow_o` and `slot_err_o` are 0.
- R2: On every advancing cycle (`stall_i` low) with no delay slot being completed, the fetch address becomes the current address plus one, wrapping modulo 2^AW.
- R3: While `stall_i` is high, the fetch address, stack contents, depth, pending target and sticky flags all hold, whatever the other inputs are.
- R4: A push without the return flag adds one entry holding its address. When both push requests are high, the immediate address is pushed and the register address is dropped.
- R5: A return without a push, on a non-empty stack, pops the top entry into the target. The next instruction (current + 1) executes, and the fetch after it is the popped address.
- R6: A push of either kind combined with a return loads the pushed address straight into the target. The stack is not pushed and not popped.
- R7: A push executed in a delay slot is stored on the stack and is unaffected by the pending target. A later return retrieves it, which is how a call gets its return address.
- R8: Addresses pushed in sequence are returned by successive returns in the reverse of push order.
- R9: Co-return with a plain return replaces the top entry with current + 2 and sends the old top to the target, leaving depth unchanged. Co-return with a push-and-return pushes current + 2. Co-return without a return has no effect.
- R10: A push while the stack holds DEPTH entries is dropped and sets `overflow_o`, which stays set until reset. `stack_full_o` is 1 exactly when depth equals DEPTH.
- R11: A return without a push on an empty stack sets `underflow_o`, which stays set until reset. No delay slot is armed, so fetch proceeds sequentially.
- R12: A return flag on a delay-slot instruction is ignored. `slot_err_o` is 1 during that cycle and 0 otherwise. Pushes in the same instruction still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Current instruction not consumed; state holds |
| push_imm_i | input | 1 | Push immediate address request |
| imm_addr_i | input | AW | Immediate absolute address |
| push_reg_i | input | 1 | Push register address request |
| reg_addr_i | input | AW | Absolute address from register file |
| ret_i | input | 1 | Return flag of the current instruction |
| coret_i | input | 1 | Co-return flag (link to current + 2) |
| fetch_addr_o | output | AW | Address of the current instruction fetch |
| depth_o | output | $clog2(DEPTH+1) | Number of stack entries |
| stack_empty_o | output | 1 | Stack holds no entries |
| stack_full_o | output | 1 | Stack holds DEPTH entries |
| overflow_o | output | 1 | Sticky: a push was dropped on a full stack |
| underflow_o | output | 1 | Sticky: a return found the stack empty |
| slot_err_o | output | 1 | Return flag seen in a delay slot this cycle |

## Verification
The bench goes after the delay-slot timing. A design that redirects one cycle early would skip the slot instruction, and one that redirects late would fetch current + 2. The push-with-return bypass is targeted because an implementation that pushes and then pops the same entry gives the right target but leaks a stack entry. Co-return and the link value current + 2 are covered, since an off-by-one there sends a call back into its own delay slot. Overflow, underflow and a return inside a delay slot are driven both directly and in a long random instruction stream, with stalls mixed in, against an arithmetic model. In that stream a swallowed push, a wrong flag or a nested redirect shows up as a divergent fetch address or depth.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic push_imm;
        logic push_reg;
        logic ret;
        logic coret;
    } ctl_bits_t;

    function automatic logic is_removal(stk_op_e op);
        return (op == STK_POP) || (op == STK_SWAP);
    endfunction

endpackage

// File: rtl/rsq_stack.sv
module rsq_stack
    import rsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  stk_op_e                    op_i,
    input  logic [AW-1:0]              wdata_i,
    output logic [AW-1:0]              top_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       empty_o,
    output logic                       full_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_m1;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] top_idx;

    assign cnt_m1  = cnt_q - CW'(1);
    assign wr_idx  = cnt_q[IW-1:0];
    assign top_idx = cnt_m1[IW-1:0];
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign count_o = cnt_q;
    assign top_o   = empty_o ? '0 : mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (op_i)
                STK_PUSH: begin
                    if (!full_o) begin
                        mem[wr_idx] <= wdata_i;
                        cnt_q       <= cnt_q + CW'(1);
                    end
                end
                STK_POP: begin
                    if (!empty_o) cnt_q <= cnt_m1;
                end
                STK_SWAP: begin
                    if (!empty_o) mem[top_idx] <= wdata_i;
                end
                default: ;
            endcase
        end
    end

    assert_no_push_full_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_PUSH) |-> !full_o);
    assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (rst)
        is_removal(op_i) |-> !empty_o);
    assert_push_grows_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_PUSH) |=> (cnt_q == $past(cnt_q) + CW'(1)));
    assert_swap_keeps_depth_R9: assert property (@(posedge clk) disable iff (rst)
        (op_i == STK_SWAP) |=> $stable(cnt_q));
    assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  ctl_bits_t     bits_i,
    input  logic [AW-1:0] imm_addr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [AW-1:0] cur_addr_i,
    input  logic [AW-1:0] stk_top_i,
    input  logic          stk_empty_i,
    input  logic          stk_full_i,
    output stk_op_e       stk_op_o,
    output logic [AW-1:0] stk_wdata_o,
    output logic          redirect_o,
    output logic [AW-1:0] target_o,
    output logic          overflow_o,
    output logic          underflow_o,
    output logic          slot_err_o
);
    logic          slot_q;
    logic [AW-1:0] target_q;
    logic          ovf_q;
    logic          unf_q;

    logic          eff_ret;
    logic          any_push;
    logic [AW-1:0] push_val;
    logic [AW-1:0] link_addr;
    logic          want_push;
    logic [AW-1:0] want_data;
    logic          arm;
    logic [AW-1:0] arm_val;
    stk_op_e       pop_kind;
    stk_op_e       op_raw;
    logic          ovf_ev;
    logic          unf_ev;

    always_comb begin
        eff_ret   = bits_i.ret & ~slot_q;
        any_push  = bits_i.push_imm | bits_i.push_reg;
        push_val  = bits_i.push_imm ? imm_addr_i : reg_addr_i;
        link_addr = cur_addr_i + AW'(2);
        want_push = 1'b0;
        want_data = push_val;
        arm       = 1'b0;
        arm_val   = stk_top_i;
        pop_kind  = STK_IDLE;
        unf_ev    = 1'b0;

        if (eff_ret && any_push) begin
            arm     = 1'b1;
            arm_val = push_val;
            if (bits_i.coret) begin
                want_push = 1'b1;
                want_data = link_addr;
            end
        end else if (any_push) begin
            want_push = 1'b1;
        end else if (eff_ret) begin
            if (stk_empty_i) begin
                unf_ev = 1'b1;
            end else begin
                arm      = 1'b1;
                pop_kind = bits_i.coret ? STK_SWAP : STK_POP;
            end
        end

        ovf_ev = 1'b0;
        op_raw = pop_kind;
        if (want_push) begin
            if (stk_full_i) begin
                ovf_ev = 1'b1;
                op_raw = STK_IDLE;
            end else begin
                op_raw = STK_PUSH;
            end
        end
    end

    assign stk_op_o    = adv_i ? op_raw : STK_IDLE;
    assign stk_wdata_o = want_push ? want_data : link_addr;
    assign redirect_o  = adv_i & slot_q;
    assign target_o    = target_q;
    assign overflow_o  = ovf_q;
    assign underflow_o = unf_q;
    assign slot_err_o  = adv_i & bits_i.ret & slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= 1'b0;
            target_q <= '0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else if (adv_i) begin
            slot_q <= arm;
            if (arm) target_q <= arm_val;
            if (ovf_ev) ovf_q <= 1'b1;
            if (unf_ev) unf_q <= 1'b1;
        end
    end

    assert_single_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (adv_i && slot_q) |=> !slot_q);
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> ($stable(slot_q) && $stable(target_q) && $stable(ovf_q) && $stable(unf_q)));
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    assert_unf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        unf_q |=> unf_q);
    assert_slot_err_only_in_slot_R12: assert property (@(posedge clk) disable iff (rst)
        slot_err_o |-> (slot_q && stk_op_o != STK_POP && stk_op_o != STK_SWAP));
    assert_underflow_no_slot_R11: assert property (@(posedge clk) disable iff (rst)
        (adv_i && unf_ev) |=> !slot_q);

endmodule

// File: rtl/rsq_pc.sv
module rsq_pc #(
    parameter int            AW         = 16,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  logic          redirect_i,
    input  logic [AW-1:0] target_i,
    output logic [AW-1:0] pc_o
);
    logic [AW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_ADDR;
        end else if (adv_i) begin
            pc_q <= redirect_i ? target_i : pc_q + AW'(1);
        end
    end

    assign pc_o = pc_q;

    assert_redirect_target_R5: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> (pc_q == $past(target_i)));
    assert_sequential_R2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !redirect_i) |=> (pc_q == $past(pc_q) + AW'(1)));
    assert_stall_pc_R3: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(pc_q));
    assert_redirect_needs_adv_R5: assert property (@(posedge clk) disable iff (rst)
        redirect_i |-> adv_i);

endmodule

// File: rtl/rsq_fetch_seq.sv
module rsq_fetch_seq
    import rsq_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            DEPTH      = 8,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stall_i,
    input  logic                       push_imm_i,
    input  logic [AW-1:0]              imm_addr_i,
    input  logic                       push_reg_i,
    input  logic [AW-1:0]              reg_addr_i,
    input  logic                       ret_i,
    input  logic                       coret_i,
    output logic [AW-1:0]              fetch_addr_o,
    output logic [$clog2(DEPTH+1)-1:0] depth_o,
    output logic                       stack_empty_o,
    output logic                       stack_full_o,
    output logic                       overflow_o,
    output logic                       underflow_o,
    output logic                       slot_err_o
);
    ctl_bits_t     bits;
    logic          adv;
    stk_op_e       stk_op;
    logic [AW-1:0] stk_wdata;
    logic [AW-1:0] stk_top;
    logic          stk_empty;
    logic          stk_full;
    logic          redirect;
    logic [AW-1:0] target;
    logic [AW-1:0] pc;

    assign adv  = ~stall_i;
    assign bits = '{push_imm: push_imm_i, push_reg: push_reg_i, ret: ret_i, coret: coret_i};

    rsq_stack #(.DEPTH(DEPTH), .AW(AW)) stack_i (
        .clk     (clk),
        .rst     (rst),
        .op_i    (stk_op),
        .wdata_i (stk_wdata),
        .top_o   (stk_top),
        .count_o (depth_o),
        .empty_o (stk_empty),
        .full_o  (stk_full)
    );

    rsq_ctrl #(.AW(AW)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .adv_i       (adv),
        .bits_i      (bits),
        .imm_addr_i  (imm_addr_i),
        .reg_addr_i  (reg_addr_i),
        .cur_addr_i  (pc),
        .stk_top_i   (stk_top),
        .stk_empty_i (stk_empty),
        .stk_full_i  (stk_full),
        .stk_op_o    (stk_op),
        .stk_wdata_o (stk_wdata),
        .redirect_o  (redirect),
        .target_o    (target),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o),
        .slot_err_o  (slot_err_o)
    );

    rsq_pc #(.AW(AW), .RESET_ADDR(RESET_ADDR)) pc_i (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (adv),
        .redirect_i (redirect),
        .target_i   (target),
        .pc_o       (pc)
    );

    assign fetch_addr_o  = pc;
    assign stack_empty_o = stk_empty;
    assign stack_full_o  = stk_full;

    assert_full_matches_depth_R10: assert property (@(posedge clk) disable iff (rst)
        stack_full_o == (depth_o == $bits(depth_o)'(DEPTH)));
    assert_bypass_keeps_depth_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && ret_i && !redirect && (push_imm_i || push_reg_i) && !coret_i) |=> $stable(depth_o));

endmodule

// File: tb/rsq_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module rsq_fetch_seq_tb_top;
    localparam int AW = 8;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall_i = 1'b1;
    logic push_imm_i = 1'b0;
    logic push_reg_i = 1'b0;
    logic ret_i = 1'b0;
    logic coret_i = 1'b0;
    logic [AW-1:0] imm_addr_i = '0;
    logic [AW-1:0] reg_addr_i = '0;
    logic [AW-1:0] fetch_addr_o;
    logic [2:0] depth_o;
    logic stack_empty_o, stack_full_o, overflow_o, underflow_o, slot_err_o;

    always #4 clk = ~clk;

    rsq_fetch_seq #(.AW(AW), .DEPTH(DEPTH), .RESET_ADDR(8'h00)) dut_i (
        .clk(clk), .rst(rst), .stall_i(stall_i),
        .push_imm_i(push_imm_i), .imm_addr_i(imm_addr_i),
        .push_reg_i(push_reg_i), .reg_addr_i(reg_addr_i),
        .ret_i(ret_i), .coret_i(coret_i),
        .fetch_addr_o(fetch_addr_o), .depth_o(depth_o),
        .stack_empty_o(stack_empty_o), .stack_full_o(stack_full_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o), .slot_err_o(slot_err_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // arithmetic reference state
    int m_pc, m_tgt, m_cnt;
    bit m_slot, m_ovf, m_unf;
    int m_stk[DEPTH];

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_pc = 0; m_tgt = 0; m_cnt = 0;
        m_slot = 0; m_ovf = 0; m_unf = 0;
    endtask

    task automatic m_push(int v);
        if (m_cnt == DEPTH) m_ovf = 1;
        else begin m_stk[m_cnt] = v; m_cnt++; end
    endtask

    task automatic m_step(bit st, bit pi, int ia, bit pr, int ra, bit rt, bit co);
        int a, nxt, pa;
        bit eret, byp, nslot;
        if (st) return;
        a = m_pc;
        eret = rt && !m_slot;
        byp = eret && (pi || pr);
        pa = pi ? ia : ra;
        nxt = m_slot ? m_tgt : ((a + 1) % 256);
        nslot = 0;
        if (byp) begin
            m_tgt = pa; nslot = 1;
            if (co) m_push((a + 2) % 256);
        end else if (pi || pr) begin
            m_push(pa);
        end else if (eret) begin
            if (m_cnt == 0) m_unf = 1;
            else begin
                m_tgt = m_stk[m_cnt-1]; nslot = 1;
                if (co) m_stk[m_cnt-1] = (a + 2) % 256;
                else m_cnt--;
            end
        end
        m_pc = nxt;
        m_slot = nslot;
    endtask

    task automatic compare_state(bit exp_err);
        check("R2/R5 fetch", int'(fetch_addr_o), m_pc);
        check("R4 depth", int'(depth_o), m_cnt);
        check("R1 empty", int'(stack_empty_o), int'(m_cnt == 0));
        check("R10 full", int'(stack_full_o), int'(m_cnt == DEPTH));
        check("R10 overflow", int'(overflow_o), int'(m_ovf));
        check("R11 underflow", int'(underflow_o), int'(m_unf));
        check("R12 slot_err", int'(slot_err_o), int'(exp_err));
    endtask

    task automatic instr(bit st, bit pi, int ia, bit pr, int ra, bit rt, bit co);
        @(negedge clk);
        stall_i = st; push_imm_i = pi; imm_addr_i = AW'(ia);
        push_reg_i = pr; reg_addr_i = AW'(ra); ret_i = rt; coret_i = co;
        #1;
        compare_state(!st && rt && m_slot);
        m_step(st, pi, ia, pr, ra, rt, co);
        @(posedge clk);
        #1;
        stall_i = 1'b1; push_imm_i = 0; push_reg_i = 0; ret_i = 0; coret_i = 0;
    endtask

    task automatic idle(); instr(0, 0, 0, 0, 0, 0, 0); endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; stall_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        #1;
        check("R1 fetch", int'(fetch_addr_o), 0);
        check("R1 depth", int'(depth_o), 0);
        check("R1 empty", int'(stack_empty_o), 1);
        check("R1 flags", int'({stack_full_o, overflow_o, underflow_o, slot_err_o}), 0);

        idle(); idle();
        check("R2 sequential", int'(fetch_addr_o), 'h02);
        // call: push+ret bypass (R6), return address pushed in delay slot (R7)
        instr(0, 1, 'h40, 0, 0, 1, 0);
        check("R6 bypass depth", int'(depth_o), 0);
        instr(0, 1, 'h10, 0, 0, 0, 0);
        check("R6 jump target", int'(fetch_addr_o), 'h40);
        check("R7 delay push kept", int'(depth_o), 1);
        // R5 plain return with delay slot
        instr(0, 0, 0, 0, 0, 1, 0);
        check("R5 delay slot sequential", int'(fetch_addr_o), 'h41);
        idle();
        check("R5 return target", int'(fetch_addr_o), 'h10);
        // R9 co-return call
        instr(0, 1, 'h80, 0, 0, 1, 1);
        check("R9 link pushed", int'(depth_o), 1);
        idle();
        check("R9 call target", int'(fetch_addr_o), 'h80);
        instr(0, 0, 0, 0, 0, 1, 0);
        idle();
        check("R9 link address", int'(fetch_addr_o), 'h12);
        // R3 stall ignores inputs
        instr(1, 1, 'h77, 0, 0, 1, 0);
        check("R3 stall fetch", int'(fetch_addr_o), 'h12);
        check("R3 stall depth", int'(depth_o), 0);
        // R11 underflow falls through
        instr(0, 0, 0, 0, 0, 1, 0);
        check("R11 underflow flag", int'(underflow_o), 1);
        check("R11 fall through", int'(fetch_addr_o), 'h13);
        // R10 overflow
        for (int i = 0; i < 5; i++) instr(0, 1, 'hA0 + i, 0, 0, 0, 0);
        check("R10 depth capped", int'(depth_o), DEPTH);
        check("R10 overflow flag", int'(overflow_o), 1);
        // R8 chain in reverse order, R12 return inside delay slot
        instr(0, 0, 0, 0, 0, 1, 0); idle();
        check("R8 first of chain", int'(fetch_addr_o), 'hA3);
        instr(0, 0, 0, 0, 0, 1, 0);
        instr(0, 0, 0, 0, 0, 1, 0);
        check("R12 slot return ignored", int'(fetch_addr_o), 'hA2);
        check("R12 depth unchanged", int'(depth_o), 2);
        instr(0, 0, 0, 0, 0, 1, 0); idle();
        check("R8 second of chain", int'(fetch_addr_o), 'hA1);
        // R4 both push requests: immediate wins
        instr(0, 1, 'h55, 1, 'h66, 0, 0);
        check("R4 one entry", int'(depth_o), 2);
        instr(0, 0, 0, 0, 0, 1, 0); idle();
        check("R4 immediate chosen", int'(fetch_addr_o), 'h55);
        // R9 co-return without return has no effect
        instr(0, 0, 0, 0, 0, 0, 1);
        check("R9 lone coret", int'(depth_o), 1);

        // near-exhaustive random instruction stream against the model
        for (int blk = 0; blk < 10; blk++) begin
            do_reset();
            for (int n = 0; n < 2000; n++) begin
                bit st, pi, pr, rt, co;
                st = ($urandom % 8) == 0;
                pi = ($urandom % 4) == 0;
                pr = ($urandom % 6) == 0;
                rt = ($urandom % 4) == 0;
                co = ($urandom % 2) == 0;
                instr(st, pi, int'($urandom % 256), pr, int'($urandom % 256), rt, co);
            end
        end
        idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule